// File: doc/BRIEF.md
# Cascaded Sampling-Depth Controller

This block steers a sampling token through eight channel rings of 1024 cells each. A mode input joins neighbouring channels into longer rings: eight rings of 1024 cells, four of 2048, two of 4096 or one of 8192. Each ring keeps its own cell position. When the token reaches the last cell of a channel it moves to the next channel of the same ring. From the last cell of the whole ring it returns to the ring's first channel.

For depth beyond one device, a cascade option reroutes ring 0 at the end of its last cell. The token leaves through the cascade output and waits until it comes back on the cascade input. The other rings continue unaffected.

A stop input freezes every ring at the same step. The mode and cascade settings are taken in only while stopped, and taking in a new setting clears every position to zero.

Top module: `sca_depth_ctrl`

## Requirements
- R1: After reset the mode is 0 and the cascade option is off. Every ring position reads 0, all eight channel enables are 1, all link bits are 0 and the cascade output is 0.
- R2: The mode code m (0..3) joins 2^m adjacent channels per ring, with rings starting at channels that are multiples of 2^m. Link bit i (i = 0..6) is 1 exactly when channel i+1 belongs to the same ring as channel i, that is when (i+1) mod 2^m is not 0.
- R3: While stop is low, each of the 8>>m active rings advances its position by 1 per clock. After reaching 1024·2^m − 1 it returns to 0.
- R4: Each active ring holding its token enables exactly one channel: index g·2^m + position/1024, where g is the ring number. A ring whose token has left the device enables none.
- R5: While stop is high and the setting inputs equal the held setting, positions, enables and the cascade output are frozen, and the cascade output is 0.
- R6: A differing mode or cascade setting is taken in on a clock edge only while stop is high, and this clears all positions and the token-away state. While stop is low a differing setting has no effect.
- R7: With cascade on, the cascade output is 1 in the cycle ring 0 sits at its last cell with stop low. On the next edge ring 0 reads position 0 with no channel enabled. The other rings are unaffected.
- R8: While ring 0's token is away, a cascade input pulse with stop low returns it: the next cycle enables ring 0's first channel at position 0, and counting resumes from there. The cascade input is ignored when the token is present or stop is high.
- R9: Position slots of rings that are not active in the current mode read 0. Slot g occupies bits 13·g+12 down to 13·g of the position bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop | input | 1 | Freeze all rings; setting changes allowed |
| cfg_mode | input | 2 | Ring grouping code m: 2^m channels per ring |
| cfg_cascade | input | 1 | Route ring 0's wrap through the cascade port |
| casc_in | input | 1 | Token returning from the next device |
| ch_en | output | 8 | Per-channel token-holding enable |
| ch_link | output | 7 | Bit i: channel i hands its token to channel i+1 |
| pos_o | output | 104 | Eight 13-bit ring positions, ring g in slot g |
| casc_out | output | 1 | Token leaving ring 0 to the next device |

## Verification
The bench raises stop in the very cycle where ring 0 sits at its last cell with cascade on. The expected result is that the cascade output stays 0 and the token does not leave. It also drives a returning cascade pulse together with stop, which must be ignored, and repeats the same pulse a cycle later with stop low, which must bring the token back. A reference model advanced at each falling edge feeds a scoreboard that compares every ring position, enable, link bit and cascade output after each rising edge.

// File: rtl/sca_depth_ctrl.sv
module sca_depth_ctrl #(
  parameter int NCH   = 8,
  parameter int CELLS = 1024,
  localparam int LW   = $clog2(NCH),
  localparam int MW   = $clog2(LW + 1),
  localparam int CW   = $clog2(CELLS),
  localparam int POSW = CW + LW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop,
  input  logic [MW-1:0]       cfg_mode,
  input  logic                cfg_cascade,
  input  logic                casc_in,
  output logic [NCH-1:0]      ch_en,
  output logic [NCH-2:0]      ch_link,
  output logic [NCH*POSW-1:0] pos_o,
  output logic                casc_out
);

  logic [MW-1:0]   mode_q;
  logic            cas_q;
  logic            away;
  logic [POSW-1:0] pos [NCH];
  logic [POSW-1:0] last;
  int              nact;
  logic            load;

  assign last     = POSW'((CELLS << mode_q) - 1);
  assign nact     = NCH >> mode_q;
  assign load     = stop && (cfg_mode != mode_q || cfg_cascade != cas_q);
  assign casc_out = !stop && cas_q && !away && (pos[0] == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cas_q  <= 1'b0;
      away   <= 1'b0;
      for (int g = 0; g < NCH; g++) pos[g] <= '0;
    end else if (load) begin
      mode_q <= cfg_mode;
      cas_q  <= cfg_cascade;
      away   <= 1'b0;
      for (int g = 0; g < NCH; g++) pos[g] <= '0;
    end else if (!stop) begin
      for (int g = 0; g < NCH; g++) begin
        if (g < nact) begin
          if (g == 0 && away) begin
            if (casc_in) away <= 1'b0;
          end else if (pos[g] == last) begin
            pos[g] <= '0;
            if (g == 0 && cas_q) away <= 1'b1;
          end else begin
            pos[g] <= pos[g] + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ch_en = '0;
    for (int g = 0; g < NCH; g++)
      if (g < nact && !(g == 0 && away))
        ch_en[(g << mode_q) + int'(pos[g] >> CW)] = 1'b1;
  end

  for (genvar i = 0; i < NCH - 1; i++) begin : g_link
    assign ch_link[i] = (((i + 1) & ((1 << mode_q) - 1)) != 0);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_pos
    assign pos_o[g*POSW +: POSW] = pos[g];
  end

endmodule

// File: rtl/sca_depth_ctrl_chk.sv
module sca_depth_ctrl_chk #(
  parameter int NCH   = 8,
  parameter int CELLS = 1024,
  localparam int LW   = $clog2(NCH),
  localparam int MW   = $clog2(LW + 1),
  localparam int CW   = $clog2(CELLS),
  localparam int POSW = CW + LW
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stop,
  input logic [MW-1:0]       cfg_mode,
  input logic                cfg_cascade,
  input logic                casc_in,
  input logic [NCH-1:0]      ch_en,
  input logic [NCH*POSW-1:0] pos_o,
  input logic                casc_out,
  input logic [MW-1:0]       mode_q,
  input logic                cas_q,
  input logic                away
);

  // R5
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && cfg_mode == mode_q && cfg_cascade == cas_q) |=> ($stable(pos_o) && $stable(ch_en)));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop |=> ($stable(mode_q) && $stable(cas_q)));

  // R4
  one_per_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !away |-> ($countones(ch_en) == (NCH >> mode_q)));

  // R7
  casc_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_out |=> (!ch_en[0] && pos_o[POSW-1:0] == '0));

  // R8
  casc_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (away && casc_in && !stop) |=> (ch_en[0] && pos_o[POSW-1:0] == '0));

endmodule

bind sca_depth_ctrl sca_depth_ctrl_chk #(.NCH(NCH), .CELLS(CELLS)) u_chk (.*);

// File: tb/sca_depth_ctrl_bench.sv
module sca_depth_ctrl_bench;
  localparam int NCH = 8, CELLS = 1024, POSW = 13;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n = 1'b0;
  logic                stop = 1'b0, cfg_cascade = 1'b0, casc_in = 1'b0;
  logic [1:0]          cfg_mode = 2'd0;
  logic [NCH-1:0]      ch_en;
  logic [NCH-2:0]      ch_link;
  logic [NCH*POSW-1:0] pos_o;
  logic                casc_out;

  sca_depth_ctrl u_sca_depth_ctrl (
    .clk(clk), .rst_n(rst_n), .stop(stop), .cfg_mode(cfg_mode),
    .cfg_cascade(cfg_cascade), .casc_in(casc_in), .ch_en(ch_en),
    .ch_link(ch_link), .pos_o(pos_o), .casc_out(casc_out));

  typedef struct {
    logic [NCH*POSW-1:0] pos;
    logic [NCH-1:0]      en;
    logic [NCH-2:0]      lnk;
    logic                cout;
    string               tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  int   m_pos[NCH];
  int   m_mode = 0;
  bit   m_cas = 1'b0, m_away = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [NCH*POSW-1:0] act, logic [NCH*POSW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t predict(bit stp, string tag);
    exp_t e;
    int last = (CELLS << m_mode) - 1;
    e.pos = '0; e.en = '0; e.lnk = '0; e.tag = tag;
    for (int g = 0; g < NCH; g++) e.pos[g*POSW +: POSW] = POSW'(m_pos[g]);
    for (int g = 0; g < (NCH >> m_mode); g++)
      if (!(g == 0 && m_away)) e.en[(g << m_mode) + m_pos[g] / CELLS] = 1'b1;
    for (int i = 0; i < NCH - 1; i++) e.lnk[i] = ((i + 1) % (1 << m_mode)) != 0;
    e.cout = !stp && m_cas && !m_away && (m_pos[0] == last);
    return e;
  endfunction

  task automatic step(bit stp, int md, bit cs, bit ci, string tag);
    int last;
    stop = stp; cfg_mode = md[1:0]; cfg_cascade = cs; casc_in = ci;
    if (stp && (md != m_mode || cs != m_cas)) begin
      m_mode = md; m_cas = cs; m_away = 1'b0;
      for (int g = 0; g < NCH; g++) m_pos[g] = 0;
    end else if (!stp) begin
      last = (CELLS << m_mode) - 1;
      for (int g = 0; g < (NCH >> m_mode); g++) begin
        if (g == 0 && m_away) begin
          if (ci) m_away = 1'b0;
        end else if (m_pos[g] == last) begin
          m_pos[g] = 0;
          if (g == 0 && m_cas) m_away = 1'b1;
        end else m_pos[g]++;
      end
    end
    q.push_back(predict(stp, tag));
    @(negedge clk);
  endtask

  task automatic run(int n, int md, bit cs, string tag);
    for (int k = 0; k < n; k++) step(1'b0, md, cs, 1'b0, tag);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() != 0) begin
      e = q.pop_front();
      chk(pos_o == e.pos, e.tag, "pos(R3/R9)", pos_o, e.pos);
      chk(ch_en == e.en, e.tag, "en(R4)", {96'd0, ch_en}, {96'd0, e.en});
      chk(ch_link == e.lnk, e.tag, "link(R2)", {97'd0, ch_link}, {97'd0, e.lnk});
      chk(casc_out == e.cout, e.tag, "cout(R7)", {103'd0, casc_out}, {103'd0, e.cout});
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NCH; g++) m_pos[g] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pos_o == '0, "R1", "pos", pos_o, '0);
    chk(ch_en == 8'hFF, "R1", "en", {96'd0, ch_en}, {96'd0, 8'hFF});
    chk(ch_link == '0 && casc_out == 1'b0, "R1", "link/cout", {96'd0, ch_link, casc_out}, '0);
    rst_n = 1'b1;
    run(1100, 0, 1'b0, "R3");
    // R8 cascade input ignored while no token is away
    for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b0, 1'b1, "R8");
    for (int k = 0; k < 5; k++) step(1'b1, 0, 1'b0, 1'b0, "R5");
    // R6 setting change ignored while running
    run(20, 2, 1'b0, "R6");
    step(1'b1, 2, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 3; k++) step(1'b1, 2, 1'b0, 1'b0, "R5");
    run(4200, 2, 1'b0, "R3");
    step(1'b1, 1, 1'b0, 1'b0, "R6");
    run(2100, 1, 1'b0, "R2");
    // R7 single 8192-cell ring with cascade
    step(1'b1, 3, 1'b1, 1'b0, "R6");
    run(8191, 3, 1'b1, "R7");
    run(6, 3, 1'b1, "R7");
    step(1'b1, 3, 1'b1, 1'b1, "R8");
    step(1'b0, 3, 1'b1, 1'b1, "R8");
    run(10, 3, 1'b1, "R8");
    // stop collides with the last cell of ring 0
    step(1'b1, 1, 1'b1, 1'b0, "R6");
    run(2047, 1, 1'b1, "R7");
    for (int k = 0; k < 3; k++) step(1'b1, 1, 1'b1, 1'b0, "R5");
    run(4, 1, 1'b1, "R7");
    step(1'b0, 1, 1'b1, 1'b1, "R8");
    run(8, 1, 1'b1, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule